// File: doc/BRIEF.md
# Byte-to-Word Packer

This block sits behind a serial byte receiver and gathers its bytes into a wide word for a memory write port. Every time the receiver pulses its done strobe, the byte on the input bus is stored in the next free byte lane of an internal 128-bit buffer. After sixteen bytes the buffer is full. The block then offers the word on the write side with a valid strobe, and holds it there until the memory side raises ready.

After the handshake the block spends one cycle clearing its lane counter, then starts packing the next word. A byte strobe that arrives while a word is still offered, or during the clearing cycle, cannot be stored. Such a byte is dropped and raises a sticky overflow flag, so that an upstream rate problem can be seen.

Byte width and lane count are parameters. The defaults are 8 bits and 16 lanes, and the lane count must be at least 2.

Top module: `byte_word_packer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, wr_valid and overflow are 0 and the lane counter is empty. The first byte accepted after a reset lands in lane 0, even if a reset cut off a partly packed word.
- R2: Byte k accepted within a word (k counts from 0 to 15) appears in wr_data bits [8k+7:8k]. The first byte therefore lands in bits [7:0].
- R3: wr_valid rises in the cycle that follows the clock edge at which the sixteenth byte strobe is sampled. It never rises before sixteen bytes have been accepted.
- R4: While wr_valid is 1 and wr_ready is 0, wr_valid stays 1 and wr_data does not change.
- R5: After a clock edge at which wr_valid and wr_ready are both 1, wr_valid is 0 for the next cycle, which is the counter-clear cycle. A byte strobe sampled at the first edge after the handshake is not stored. A byte strobe sampled at the second edge after the handshake becomes lane 0 of the next word.
- R6: A byte strobe sampled while wr_valid is 1, or during the counter-clear cycle, is dropped. From the next cycle on, overflow is 1 and stays 1 until reset.
- R7: A change on rx_byte while rx_done is 0 stores nothing and does not advance the lane counter.
- R8: Byte strobes on consecutive cycles are all stored, with no byte lost or doubled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_done | input | 1 | One-cycle strobe: rx_byte is valid |
| wr_data | output | 128 | Packed word, lane 0 in the low bits |
| wr_valid | output | 1 | Word on wr_data is offered for writing |
| wr_ready | input | 1 | Memory side accepts the word at this edge |
| overflow | output | 1 | Sticky: a byte was dropped because no lane was free |

## Verification
The assertions assume that rx_done, rx_byte and wr_ready are synchronous to clk and hold a defined value at every sampled edge. They also assume that wr_ready is sampled only as a qualifier of wr_valid, so the memory side may raise it early. The bench drives these inputs one full cycle at a time, from the falling edge. It gates rx_done to the packing phase for every scenario except the deliberate overflow case, and only that scenario sends a byte into a pending word or into the clear cycle. The wr_ready pattern is random, so hold periods of different lengths occur, and each such period ends in a finite number of cycles.

// File: rtl/packer_pkg.sv
package packer_pkg;

  // Phases of the packer: gathering bytes, offering a full word, clearing counters.
  typedef enum logic [1:0] {
    PK_FILL  = 2'd0,
    PK_ISSUE = 2'd1,
    PK_CLEAR = 2'd2
  } pk_state_e;

endpackage

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import packer_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_done,
  input  logic             wr_ready,
  output logic [LANES-1:0] lane_we,
  output logic             wr_valid,
  output logic             drop
);

  localparam int CNT_W = $clog2(LANES);
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(LANES - 1);

  pk_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign accept = rx_done && (state_q == PK_FILL);

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PK_FILL: begin
        if (rx_done) begin
          if (cnt_q == LAST_LANE) begin
            state_d = PK_ISSUE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PK_ISSUE: begin
        if (wr_ready) state_d = PK_CLEAR;
      end
      PK_CLEAR: begin
        cnt_d   = '0;
        state_d = PK_FILL;
      end
      default: begin
        cnt_d   = '0;
        state_d = PK_FILL;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PK_FILL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // One write enable per byte lane
  for (genvar i = 0; i < LANES; i++) begin : g_we
    assign lane_we[i] = accept && (cnt_q == CNT_W'(i));
  end

  assign wr_valid = (state_q == PK_ISSUE);
  assign drop     = rx_done && (state_q != PK_FILL);

  // R5: a handshake is followed by one cycle with no word offered
  assert_clear_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);

  // R5: the clear cycle leaves the counter empty and packing enabled
  assert_fill_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PK_CLEAR) |=> (state_q == PK_FILL && cnt_q == '0));

  // R3: a word is offered only after the last lane was written
  assert_issue_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(lane_we[LANES-1]));

endmodule

// File: rtl/packer_lane_store.sv
module packer_lane_store #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_we,
  input  logic [BYTE_W-1:0]       din,
  output logic [BYTE_W*LANES-1:0] word
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_we[i]) begin
        lane_q <= din;
      end
    end
    assign word[i*BYTE_W +: BYTE_W] = lane_q;
  end

  // R2: at most one lane is written per byte
  assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

endmodule

// File: rtl/packer_sticky_flag.sv
module packer_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R6: once raised the flag holds until reset
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       rx_byte,
  input  logic                    rx_done,
  output logic [BYTE_W*LANES-1:0] wr_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic                    overflow
);

  logic [LANES-1:0] lane_we;
  logic             drop;

  packer_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_done  (rx_done),
    .wr_ready (wr_ready),
    .lane_we  (lane_we),
    .wr_valid (wr_valid),
    .drop     (drop)
  );

  packer_lane_store #(.BYTE_W(BYTE_W), .LANES(LANES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we (lane_we),
    .din     (rx_byte),
    .word    (wr_data)
  );

  packer_sticky_flag u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (drop),
    .flag  (overflow)
  );

  // R4: an offered word is held until accepted
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  // R6: a byte arriving while a word is pending raises overflow
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && wr_valid) |=> overflow);

  // R1: nothing is offered or flagged in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !overflow));

endmodule

// File: tb/sim_byte_word_packer.sv
`timescale 1ns/1ps
module sim_byte_word_packer;

  localparam int BW = 8;
  localparam int NL = 16;

  logic            clk;
  logic            rst_n;
  logic [BW-1:0]   rx_byte;
  logic            rx_done;
  logic [BW*NL-1:0] wr_data;
  logic            wr_valid;
  logic            wr_ready;
  logic            overflow;

  int checks = 0;
  int errors = 0;

  // Behavioural reference: pending bytes, phase (0 packing, 1 offered, 2 clearing)
  logic [BW-1:0]    mq[$];
  int               mphase = 0;
  logic [BW*NL-1:0] mword = '0;
  bit               movf = 0;

  byte_word_packer #(.BYTE_W(BW), .LANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_done(rx_done),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .overflow(overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [BW*NL-1:0] act, input logic [BW*NL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(wr_valid == (mphase == 1), tag, "wr_valid", wr_valid, (mphase == 1));
    check(overflow == movf, tag, "overflow", overflow, movf);
    if (mphase == 1) check(wr_data == mword, tag, "wr_data", wr_data, mword);
  endtask

  task automatic model_reset();
    mq.delete();
    mphase = 0;
    movf = 0;
  endtask

  // Drive one cycle from the falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic step(input bit d, input logic [BW-1:0] b, input bit r, input string tag);
    rx_done = d; rx_byte = b; wr_ready = r;
    @(posedge clk);
    case (mphase)
      0: if (d) begin
           mq.push_back(b);
           if (mq.size() == NL) begin
             for (int k = 0; k < NL; k++) mword[k*BW +: BW] = mq[k];
             mq.delete();
             mphase = 1;
           end
         end
      1: begin
           if (d) movf = 1;
           if (r) mphase = 2;
         end
      default: begin
           if (d) movf = 1;
           mphase = 0;
         end
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; rx_done = 1'b0; rx_byte = '0; wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!wr_valid && !overflow, tag, "in reset", {wr_valid, overflow}, 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    compare(tag);
  endtask

  // One word with random gaps (junk bytes on idle cycles), then drain with a ready pattern.
  task automatic feed_word(input int gap_max, input bit rand_ready, input string tag);
    for (int n = 0; n < NL; n++) begin
      int g = (gap_max > 0) ? $urandom_range(0, gap_max) : 0;
      for (int j = 0; j < g; j++) step(1'b0, 8'($urandom), 1'b0, tag);
      step(1'b1, 8'($urandom), 1'b0, tag);
    end
    while (mphase != 0) step(1'b0, 8'($urandom), rand_ready ? 1'($urandom_range(0, 1)) : 1'b1, tag);
  endtask

  initial begin
    rst_n = 1'b0; rx_done = 1'b0; rx_byte = '0; wr_ready = 1'b0;
    @(negedge clk);
    do_reset("R1");

    // R7: bytes toggling without a strobe are ignored; the next word shows only strobed bytes
    for (int j = 0; j < 6; j++) step(1'b0, 8'($urandom), 1'b1, "R7");
    feed_word(0, 1'b0, "R7");

    // R2 and R3: lane order and valid timing under random gaps
    for (int w = 0; w < 4; w++) feed_word(3, 1'b0, "R2");
    feed_word(5, 1'b0, "R3");

    // R8: bytes on consecutive cycles
    for (int w = 0; w < 3; w++) feed_word(0, 1'b0, "R8");

    // R4: word held with ready low, then random ready
    for (int n = 0; n < NL; n++) step(1'b1, 8'(n * 17 + 3), 1'b0, "R4");
    for (int j = 0; j < 7; j++) step(1'b0, 8'hEE, 1'b0, "R4");
    step(1'b0, 8'hEE, 1'b1, "R4");
    for (int w = 0; w < 4; w++) feed_word(2, 1'b1, "R4");

    // R5: handshake, clear cycle with no strobe, then a byte at the second edge becomes lane 0
    for (int n = 0; n < NL; n++) step(1'b1, 8'(8'hA0 + n), 1'b0, "R5");
    step(1'b0, 8'h00, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b0, "R5");
    step(1'b1, 8'h5A, 1'b0, "R5");
    for (int n = 1; n < NL; n++) step(1'b1, 8'(n), 1'b0, "R5");
    step(1'b0, 8'h00, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b0, "R5");

    // R5 and R6: a byte during the clear cycle is dropped and flags overflow
    for (int n = 0; n < NL; n++) step(1'b1, 8'(8'hC0 + n), 1'b0, "R5");
    step(1'b0, 8'h00, 1'b1, "R5");
    step(1'b1, 8'hFF, 1'b0, "R6");
    feed_word(0, 1'b0, "R6");

    // R6: byte while a word is pending; flag stays high
    do_reset("R1");
    for (int n = 0; n < NL; n++) step(1'b1, 8'($urandom), 1'b0, "R6");
    step(1'b1, 8'h77, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b0, "R6");
    step(1'b1, 8'h78, 1'b1, "R6");
    for (int w = 0; w < 2; w++) feed_word(1, 1'b1, "R6");

    // R1: reset in the middle of a word empties the counter
    for (int n = 0; n < 5; n++) step(1'b1, 8'($urandom), 1'b0, "R1");
    do_reset("R1");
    feed_word(1, 1'b0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule